// File: doc/BRIEF.md
# Performance-state mailbox responder

This block sits on the coprocessor side of a host/coprocessor mailbox. It serves requests about CPU performance states. The host sees a small register file on a simple register bus. The file holds a command register, a status register, four parameter words, a constant identification word, a current-state register and a current-frequency register. To issue a request, the host clears status, loads the parameters and writes a nonzero command code. It then pulses a doorbell. A hardware engine carries out the request and writes its results into the parameter words. It then posts a status byte, returns the command register to zero and raises a one-cycle completion interrupt toward the host.

The engine keeps a performance map: a mode, two divider words and an initial state. It also keeps the index of the selected state. The map can be loaded once after reset, and a state can be selected only after the map is loaded. Each refused request reports its own status code. The block does not program regulators or clock dividers. It only holds the state index and reports that state's frequency from a parameter table.

Top module: `pstate_mailbox`

## Requirements
- R1: After reset the command, status and state registers read 0, no map is loaded, the frequency register reads the state-0 table entry (1500 MHz by default), and the interrupt is low.
- R2: Register offsets are as follows. Command is at 0x00 (8-bit code, zero-extended). Status is at 0x04. The parameters are at 0x18, 0x1C, 0x20 and 0x24. The state index is at 0x2C. The constant 0xA11600D1 is at 0x34. The frequency in MHz is at 0x50. Command, status and the parameters are host-writable.
- R3: The doorbell is sampled on edge E0. Status holds the result after edge E1, while command still holds the code. Command reads 0 after E2. The interrupt is high only between E3 and E4.
- R4: A doorbell while the command register is 0 is ignored: status keeps its value and no interrupt follows.
- R5: Codes 0x10, 0x11, 0x12 and 0x13 complete with status 0xF0 and change nothing. Any code that is neither these nor 0x30, 0x31, 0x40 or 0x41 completes with status 0xF1.
- R6: Set-state (0x41) before any map is loaded returns 0xF3 and leaves the state at 0.
- R7: Set-map (0x31) takes the mode from parameter 0, the divider words from parameters 1 and 2, and the initial state from parameter 3. A mode above 3 returns 0xF2, and an initial state above 4 returns 0xFF; in both cases nothing is stored. Otherwise it returns 0xF0, stores the map and selects the initial state.
- R8: A set-map while a map is already loaded returns 0xF4 and leaves the map and the selected state unchanged.
- R9: Once a map is loaded, set-state with parameter 0 in 0..4 returns 0xF0 and selects that state. A value above 4 returns 0xFF and keeps the previous state.
- R10: Get-state (0x40) returns the selected state in parameter 0. Get-map (0x30) returns mode, divider word 1, divider word 2 and the initial state in parameters 0..3. That initial state can differ from the selected one. Both return status 0xF0.
- R11: The frequency register reports the table entry of the selected state: by default 1500, 1000, 750, 500 and 375 MHz for states 0..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| doorbell | input | 1 | Request to process the current command |
| host_irq | output | 1 | One-cycle completion interrupt |

## Verification
Every result has a fixed place in the timeline counted from the edge that samples the doorbell. The status byte and the parameter results are due one edge later, and the command clear two edges later. The interrupt rises three edges later and falls on the fourth. The bench drives inputs and reads the combinational read port at falling edges. For every command it checks status and command after the first and second rising edges, the interrupt after the third and fourth, and the parameter words and state and frequency registers only after the interrupt has fallen. That way each value is observed in the exact cycle it is due, and in no earlier cycle.

// File: rtl/pstate_mailbox.sv
module pstate_mailbox #(
  parameter int NUM_STATES = 5,
  parameter int FREQ_W = 16,
  parameter logic [NUM_STATES*FREQ_W-1:0] FREQ_MHZ =
    {16'd375, 16'd500, 16'd750, 16'd1000, 16'd1500}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        doorbell,
  output logic        host_irq
);
  localparam int SW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1;
  localparam int MAX_STATE = NUM_STATES - 1;
  localparam logic [31:0] MAGIC = 32'hA11600D1;

  localparam logic [7:0] C_DISABLE   = 8'h10;
  localparam logic [7:0] C_ENABLE    = 8'h11;
  localparam logic [7:0] C_SLEEP_IN  = 8'h12;
  localparam logic [7:0] C_SLEEP_OUT = 8'h13;
  localparam logic [7:0] C_GET_MAP   = 8'h30;
  localparam logic [7:0] C_SET_MAP   = 8'h31;
  localparam logic [7:0] C_GET_STATE = 8'h40;
  localparam logic [7:0] C_SET_STATE = 8'h41;

  localparam logic [7:0] S_OK      = 8'hF0;
  localparam logic [7:0] S_UNKNOWN = 8'hF1;
  localparam logic [7:0] S_BADMODE = 8'hF2;
  localparam logic [7:0] S_NOMAP   = 8'hF3;
  localparam logic [7:0] S_MAPSET  = 8'hF4;
  localparam logic [7:0] S_FAIL    = 8'hFF;

  typedef enum logic [1:0] {E_IDLE, E_EXEC, E_CLEAR, E_NOTIFY} eng_t;

  eng_t          st;
  logic [7:0]    cmd_q, status_q, op_q;
  logic [31:0]   par [4];
  logic          map_ok;
  logic [1:0]    map_mode;
  logic [31:0]   map_div1, map_div2;
  logic [SW-1:0] map_state, cur_state;
  logic [FREQ_W-1:0] freq_now;

  assign freq_now = FREQ_MHZ[cur_state*FREQ_W +: FREQ_W];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = {24'b0, cmd_q};
      8'h04: bus_rdata = {24'b0, status_q};
      8'h18: bus_rdata = par[0];
      8'h1C: bus_rdata = par[1];
      8'h20: bus_rdata = par[2];
      8'h24: bus_rdata = par[3];
      8'h2C: bus_rdata = {{(32-SW){1'b0}}, cur_state};
      8'h34: bus_rdata = MAGIC;
      8'h50: bus_rdata = {{(32-FREQ_W){1'b0}}, freq_now};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cmd_q     <= '0;
      status_q  <= '0;
      op_q      <= '0;
      for (int i = 0; i < 4; i++) par[i] <= '0;
      map_ok    <= 1'b0;
      map_mode  <= '0;
      map_div1  <= '0;
      map_div2  <= '0;
      map_state <= '0;
      cur_state <= '0;
      host_irq  <= 1'b0;
    end else begin
      host_irq <= (st == E_NOTIFY);
      if (bus_we) begin
        case (bus_addr)
          8'h00: cmd_q    <= bus_wdata[7:0];
          8'h04: status_q <= bus_wdata[7:0];
          8'h18: par[0]   <= bus_wdata;
          8'h1C: par[1]   <= bus_wdata;
          8'h20: par[2]   <= bus_wdata;
          8'h24: par[3]   <= bus_wdata;
          default: ;
        endcase
      end
      case (st)
        E_IDLE: if (doorbell && cmd_q != 8'h00) begin
          op_q <= cmd_q;
          st   <= E_EXEC;
        end
        E_EXEC: begin
          st <= E_CLEAR;
          case (op_q)
            C_GET_MAP: begin
              par[0]   <= {30'b0, map_mode};
              par[1]   <= map_div1;
              par[2]   <= map_div2;
              par[3]   <= {{(32-SW){1'b0}}, map_state};
              status_q <= S_OK;
            end
            C_SET_MAP: begin
              if (map_ok)                           status_q <= S_MAPSET;
              else if (par[0] > 32'd3)              status_q <= S_BADMODE;
              else if (par[3] > 32'(MAX_STATE))     status_q <= S_FAIL;
              else begin
                map_ok    <= 1'b1;
                map_mode  <= par[0][1:0];
                map_div1  <= par[1];
                map_div2  <= par[2];
                map_state <= par[3][SW-1:0];
                cur_state <= par[3][SW-1:0];
                status_q  <= S_OK;
              end
            end
            C_GET_STATE: begin
              par[0]   <= {{(32-SW){1'b0}}, cur_state};
              status_q <= S_OK;
            end
            C_SET_STATE: begin
              if (!map_ok)                          status_q <= S_NOMAP;
              else if (par[0] > 32'(MAX_STATE))     status_q <= S_FAIL;
              else begin
                cur_state <= par[0][SW-1:0];
                status_q  <= S_OK;
              end
            end
            C_DISABLE, C_ENABLE, C_SLEEP_IN, C_SLEEP_OUT: status_q <= S_OK;
            default: status_q <= S_UNKNOWN;
          endcase
        end
        E_CLEAR: begin
          cmd_q <= 8'h00;
          st    <= E_NOTIFY;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pstate_mailbox_sva.sv
module pstate_mailbox_sva #(
  parameter int NUM_STATES = 5,
  localparam int SW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_irq,
  input logic [7:0]    cmd_q,
  input logic [7:0]    status_q,
  input logic          map_ok,
  input logic [1:0]    map_mode,
  input logic [31:0]   map_div1,
  input logic [31:0]   map_div2,
  input logic [SW-1:0] map_state,
  input logic [SW-1:0] cur_state
);
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

  a_r3_irq_after_status_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (cmd_q == 8'h00 && status_q != 8'h00));

  a_r9_state_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state <= SW'(NUM_STATES - 1));

  a_r6_no_map_state_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !map_ok |-> cur_state == '0);

  a_r8_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    map_ok |=> (map_ok && $stable(map_mode) && $stable(map_div1)
                && $stable(map_div2) && $stable(map_state)));
endmodule

bind pstate_mailbox pstate_mailbox_sva #(.NUM_STATES(NUM_STATES)) u_sva (
  .clk(clk), .rst_n(rst_n), .host_irq(host_irq), .cmd_q(cmd_q),
  .status_q(status_q), .map_ok(map_ok), .map_mode(map_mode),
  .map_div1(map_div1), .map_div2(map_div2), .map_state(map_state),
  .cur_state(cur_state)
);

// File: tb/pstate_mailbox_test.sv
module pstate_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        doorbell = 1'b0;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pstate_mailbox uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .doorbell(doorbell),
    .host_irq(host_irq)
  );

  function automatic logic [31:0] exp_freq(int s);
    case (s)
      0: return 32'd1500;
      1: return 32'd1000;
      2: return 32'd750;
      3: return 32'd500;
      default: return 32'd375;
    endcase
  endfunction

  function automatic logic [7:0] sweep_status(int c);
    if (c >= 8'h10 && c <= 8'h13) return 8'hF0;
    if (c == 8'h30 || c == 8'h40) return 8'hF0;
    if (c == 8'h41) return 8'hF3;
    return 8'hF1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic run(input logic [7:0] c, input logic [7:0] exp_st, input string req);
    wr(8'h04, 32'h0);
    wr(8'h00, {24'b0, c});
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    check(host_irq == 1'b0, "R3 irq low after E0", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    expect_reg(8'h04, {24'b0, exp_st}, req);
    expect_reg(8'h00, {24'b0, c}, "R3 command held after E1");
    @(negedge clk);
    expect_reg(8'h00, 32'h0, "R3 command cleared after E2");
    check(host_irq == 1'b0, "R3 irq low after E2", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    check(host_irq == 1'b1, "R3 irq high after E3", {31'b0, host_irq}, 32'h1);
    @(negedge clk);
    check(host_irq == 1'b0, "R3 irq low after E4", {31'b0, host_irq}, 32'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 offsets
    expect_reg(8'h00, 32'h0, "R1 command");
    expect_reg(8'h04, 32'h0, "R1 status");
    expect_reg(8'h2C, 32'h0, "R1 state");
    expect_reg(8'h50, 32'd1500, "R1 freq");
    expect_reg(8'h34, 32'hA11600D1, "R2 magic");
    check(host_irq == 1'b0, "R1 irq", {31'b0, host_irq}, 32'h0);
    wr(8'h20, 32'hCAFE0123);
    expect_reg(8'h20, 32'hCAFE0123, "R2 param2 writable");

    // R4 doorbell with zero command
    wr(8'h04, 32'hAB);
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(host_irq == 1'b0, "R4 no irq", {31'b0, host_irq}, 32'h0);
      @(negedge clk);
    end
    expect_reg(8'h04, 32'hAB, "R4 status kept");

    // R5 sweep of all codes before a map exists
    wr(8'h18, 32'd2);
    for (int c = 1; c < 256; c++) begin
      if (c != 8'h31) run(8'(c), sweep_status(c), $sformatf("R5 status code %02h", c));
      if (c == 8'h40) wr(8'h18, 32'd2);
    end
    expect_reg(8'h2C, 32'h0, "R5 state unchanged by sweep");

    // R6 set-state without map
    wr(8'h18, 32'd3);
    run(8'h41, 8'hF3, "R6 status");
    expect_reg(8'h2C, 32'h0, "R6 state stays 0");

    // R7 rejected loads
    wr(8'h18, 32'd4); wr(8'h1C, 32'h11); wr(8'h20, 32'h22); wr(8'h24, 32'd1);
    run(8'h31, 8'hF2, "R7 bad mode");
    wr(8'h18, 32'd3); wr(8'h24, 32'd7);
    run(8'h31, 8'hFF, "R7 bad initial state");
    wr(8'h18, 32'd1);
    run(8'h41, 8'hF3, "R7 nothing stored after rejects");
    // R7 valid load
    wr(8'h18, 32'd3); wr(8'h1C, 32'h00020464); wr(8'h20, 32'h05040302); wr(8'h24, 32'd2);
    run(8'h31, 8'hF0, "R7 load ok");
    expect_reg(8'h2C, 32'd2, "R7 initial state selected");
    expect_reg(8'h50, 32'd750, "R11 freq state 2");

    // R8 second load refused
    wr(8'h18, 32'd1); wr(8'h1C, 32'h1); wr(8'h20, 32'h2); wr(8'h24, 32'd0);
    run(8'h31, 8'hF4, "R8 status");
    expect_reg(8'h2C, 32'd2, "R8 state unchanged");
    for (int i = 0; i < 4; i++) wr(8'(8'h18 + 4*i), 32'hFFFFFFFF);
    run(8'h30, 8'hF0, "R10 get-map status");
    expect_reg(8'h18, 32'd3, "R8 mode kept");
    expect_reg(8'h1C, 32'h00020464, "R8 div1 kept");
    expect_reg(8'h20, 32'h05040302, "R8 div2 kept");
    expect_reg(8'h24, 32'd2, "R8 initial state kept");

    // R9 / R11 state sweep
    for (int s = 0; s < 8; s++) begin
      wr(8'h18, 32'(s));
      run(8'h41, (s <= 4) ? 8'hF0 : 8'hFF, $sformatf("R9 set-state %0d", s));
      expect_reg(8'h2C, (s <= 4) ? 32'(s) : 32'd4, "R9 selected state");
      expect_reg(8'h50, exp_freq((s <= 4) ? s : 4), "R11 freq");
    end

    // R10 readback of current vs recorded state
    wr(8'h18, 32'd1);
    run(8'h41, 8'hF0, "R10 select 1");
    wr(8'h18, 32'hFFFFFFFF);
    run(8'h40, 8'hF0, "R10 get-state status");
    expect_reg(8'h18, 32'd1, "R10 get-state value");
    wr(8'h24, 32'hFFFFFFFF);
    run(8'h30, 8'hF0, "R10 get-map status");
    expect_reg(8'h24, 32'd2, "R10 map keeps initial state");
    expect_reg(8'h50, 32'd1000, "R11 freq state 1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule